// File: doc/BRIEF.md
# Three-Phase Sine PWM Bridge Driver

This block drives the six gate outputs of a three-phase bridge, two per phase, with sinusoidal pulse-width modulation. One electrical revolution is split into 64 index steps, and only 16 of them are stored: a quarter of a sine wave, held in a small constant table inside the module. A full wave is rebuilt from that quarter. In the second and fourth quadrants the table address is mirrored, and in the third and fourth the value is negated. The U phase follows a rotating index. The V and W phases sit one and two programmable spacings ahead of it.

Each signed sample is shifted onto an unsigned 8-bit duty value centred on mid-scale. That duty is compared with a free-running 8-bit carrier. Each phase passes through its own dead-time stage before it reaches the pins. An active-low brake input overrides everything: all high sides go off and all low sides go on.

A controller selects the sine mode with a 2-bit mode field and the enable bit. It sets the speed with a step period counted in slow tick strobes, and the rotation order with a direction bit.

Top module: `sine_bridge_pwm`

## Requirements
- R1: While reset is held and after it is released with enable low and brake released, all six outputs are low. The rotation index and the carrier both start at 0.
- R2: The block runs only while enable is 1 and mode equals 2. Otherwise, with brake released, all six outputs stay low, and tick strobes do not advance the rotation index.
- R3: Let q be bits [5:4] and i be bits [3:0] of a phase index. The table T holds T[i] = round(127·sin((2i+1)·π/64)). The amplitude a is T[i] when q is even and T[15−i] when q is odd. The duty is 128+a when q < 2 and 128−a when q ≥ 2.
- R4: The 8-bit carrier advances by one on every active clock and wraps from 255 to 0. A phase's high side wants to be on while its duty is greater than the carrier. With zero dead time, over any 256 steady active cycles the high side is on for exactly duty cycles and the low side for 256−duty cycles.
- R5: The U index is the rotation index. The V index is U+S and the W index is U+2S, modulo 64, where S is the 16-bit spacing input taken modulo 64.
- R6: The rotation index moves by one step after every P active tick strobes, where P is the period input (0 and 1 both mean every strobe).
- R7: When the direction input is 1 the index increments on each step, and when it is 0 it decrements.
- R8: After a phase's wanted side changes, both of its outputs stay low for D clocks, where D is the dead-time input. Over 256 steady cycles the high side is on for max(duty−D,0) cycles and the low side for max(256−duty−D,0) cycles.
- R9: While the brake input is low, all three high-side outputs are 0 and all three low-side outputs are 1 in the same cycle, whatever the enable and mode inputs are.
- R10: A phase never has its high-side and low-side outputs on at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global enable |
| mode | input | 2 | Drive mode select; 2 selects sine PWM |
| dir | input | 1 | Rotation direction, 1 increments the index |
| dead_ticks | input | 4 | Dead time in clocks |
| step_period | input | 16 | Tick strobes per index step |
| phase_gap | input | 16 | Index spacing between phases (used modulo 64) |
| slow_tick | input | 1 | Slow time-base strobe, one clock wide |
| brake_n | input | 1 | Active-low brake |
| hs | output | 3 | High-side gate drives, bit 0 = U, 1 = V, 2 = W |
| ls | output | 3 | Low-side gate drives, bit 0 = U, 1 = V, 2 = W |

## Verification
A wrong mirror or sign in the quadrant mapping shows up as the wrong high-side on-count in the first full carrier period, 256 clocks, at the affected index. Every index is visited in both directions, so a fault of this kind cannot stay hidden. A rotation index that slips, or steps on the wrong number of strobes, moves all three duties at once. It is caught at the next measured index, and a wrong spacing moves only the V and W counts. A broken dead-time counter changes both on-counts of a phase by a fixed amount in every period, and a missed brake shows up in the same cycle the brake input falls.

// File: rtl/sine_bridge_pwm.sv
module sine_bridge_pwm #(
  parameter int PERIOD_W = 16,
  parameter int DEAD_W   = 4,
  parameter int GAP_W    = 16,
  parameter logic [1:0] SINE_MODE = 2'd2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [1:0]          mode,
  input  logic                dir,
  input  logic [DEAD_W-1:0]   dead_ticks,
  input  logic [PERIOD_W-1:0] step_period,
  input  logic [GAP_W-1:0]    phase_gap,
  input  logic                slow_tick,
  input  logic                brake_n,
  output logic [2:0]          hs,
  output logic [2:0]          ls
);
  localparam int QB  = 4;
  localparam int IW  = QB + 2;
  localparam int AW  = 7;
  localparam int CW  = AW + 1;
  localparam int MID = 1 << (CW - 1);

  function automatic logic [AW-1:0] quarter_sine(input logic [QB-1:0] a);
    case (a)
      4'd0:  quarter_sine = 7'd6;
      4'd1:  quarter_sine = 7'd19;
      4'd2:  quarter_sine = 7'd31;
      4'd3:  quarter_sine = 7'd43;
      4'd4:  quarter_sine = 7'd54;
      4'd5:  quarter_sine = 7'd65;
      4'd6:  quarter_sine = 7'd76;
      4'd7:  quarter_sine = 7'd85;
      4'd8:  quarter_sine = 7'd94;
      4'd9:  quarter_sine = 7'd102;
      4'd10: quarter_sine = 7'd109;
      4'd11: quarter_sine = 7'd115;
      4'd12: quarter_sine = 7'd120;
      4'd13: quarter_sine = 7'd123;
      4'd14: quarter_sine = 7'd126;
      default: quarter_sine = 7'd127;
    endcase
  endfunction

  logic                active;
  logic [PERIOD_W-1:0] tcnt;
  logic [PERIOD_W:0]   tnext;
  logic [IW-1:0]       ph;
  logic [IW-1:0]       pgap;
  logic [CW-1:0]       car, car_q;

  assign active = enable && (mode == SINE_MODE);
  assign tnext  = {1'b0, tcnt} + {{PERIOD_W{1'b0}}, 1'b1};
  assign pgap   = IW'(phase_gap % GAP_W'(1 << IW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt  <= '0;
      ph    <= '0;
      car   <= '0;
      car_q <= '0;
    end else if (active) begin
      car   <= car + 1'b1;
      car_q <= car;
      if (slow_tick) begin
        if (tnext >= {1'b0, step_period}) begin
          tcnt <= '0;
          ph   <= dir ? ph + 1'b1 : ph - 1'b1;
        end else begin
          tcnt <= tnext[PERIOD_W-1:0];
        end
      end
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_phase
    logic [IW-1:0]     idx;
    logic [QB-1:0]     addr;
    logic [AW-1:0]     amp_q;
    logic              neg_q;
    logic [CW-1:0]     duty;
    logic              want, side;
    logic [DEAD_W-1:0] gap;

    assign idx  = ph + IW'(k) * pgap;
    assign addr = idx[QB] ? ~idx[QB-1:0] : idx[QB-1:0];
    assign duty = neg_q ? (CW'(MID) - {1'b0, amp_q}) : (CW'(MID) + {1'b0, amp_q});
    assign want = duty > car_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        amp_q <= '0;
        neg_q <= 1'b0;
        side  <= 1'b0;
        gap   <= '0;
      end else if (active) begin
        amp_q <= quarter_sine(addr);
        neg_q <= idx[IW-1];
        if (want != side) begin
          side <= want;
          gap  <= dead_ticks;
        end else if (gap != '0) begin
          gap <= gap - 1'b1;
        end
      end
    end

    assign hs[k] = brake_n && active &&  side && (gap == '0);
    assign ls[k] = !brake_n || (active && !side && (gap == '0));
  end
endmodule

// File: rtl/sine_bridge_pwm_chk.sv
module sine_bridge_pwm_chk #(
  parameter int PERIOD_W = 16,
  parameter int DEAD_W   = 4,
  parameter int IW       = 6,
  parameter int CW       = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                active,
  input logic                slow_tick,
  input logic                dir,
  input logic                brake_n,
  input logic [PERIOD_W-1:0] step_period,
  input logic [DEAD_W-1:0]   dead_ticks,
  input logic [IW-1:0]       ph,
  input logic [CW-1:0]       car,
  input logic [2:0]          hs,
  input logic [2:0]          ls
);
  assert_carrier_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> car == CW'($past(car) + 1'b1));

  assert_index_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!active) |-> $stable(ph));

  assert_index_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active && slow_tick && (step_period <= 1)) |->
      ph == ($past(dir) ? IW'($past(ph) + 1'b1) : IW'($past(ph) - 1'b1)));

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hs & ls) == 3'b000);

  for (genvar k = 0; k < 3; k++) begin : g_dead
    assert_gap_before_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hs[k]) && $past(brake_n) && ($past(dead_ticks) != 0)) |-> !$past(ls[k]));
    assert_gap_before_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ls[k]) && brake_n && ($past(dead_ticks) != 0)) |-> !$past(hs[k]));
  end
endmodule

bind sine_bridge_pwm sine_bridge_pwm_chk #(
  .PERIOD_W(PERIOD_W), .DEAD_W(DEAD_W), .IW(IW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .slow_tick(slow_tick), .dir(dir),
  .brake_n(brake_n), .step_period(step_period), .dead_ticks(dead_ticks),
  .ph(ph), .car(car), .hs(hs), .ls(ls)
);

// File: tb/sine_bridge_pwm_tb.sv
module sine_bridge_pwm_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        dir = 1'b1;
  logic [3:0]  dead_ticks = 4'd0;
  logic [15:0] step_period = 16'd3;
  logic [15:0] phase_gap = 16'd21;
  logic        slow_tick = 1'b0;
  logic        brake_n = 1'b1;
  logic [2:0]  hs, ls;

  int n_cmp = 0;
  int n_bad = 0;
  int tbl[16];

  always #(CLK_P/2) clk = ~clk;

  sine_bridge_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .dir(dir),
    .dead_ticks(dead_ticks), .step_period(step_period), .phase_gap(phase_gap),
    .slow_tick(slow_tick), .brake_n(brake_n), .hs(hs), .ls(ls)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_duty(input int idx);
    int q = (idx >> 4) & 3;
    int i = idx & 15;
    int a = (q % 2 == 1) ? tbl[15 - i] : tbl[i];
    return (q >= 2) ? 128 - a : 128 + a;
  endfunction

  task automatic pulse_ticks(input int n);
    for (int t = 0; t < n; t++) begin
      @(negedge clk) slow_tick = 1'b1;
      @(negedge clk) slow_tick = 1'b0;
    end
  endtask

  // R3 R4 R5 R8 R10: one steady carrier period, counted per phase
  task automatic check_step(input int u, input int sp, input int d);
    int hc[3];
    int lc[3];
    int both;
    both = 0;
    for (int k = 0; k < 3; k++) begin hc[k] = 0; lc[k] = 0; end
    repeat (24) @(negedge clk);
    repeat (256) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        hc[k] += int'(hs[k]);
        lc[k] += int'(ls[k]);
        both  += int'(hs[k] & ls[k]);
      end
    end
    for (int k = 0; k < 3; k++) begin
      int idx = (u + k * sp) & 63;
      int dt = exp_duty(idx);
      int eh = (dt - d > 0) ? dt - d : 0;
      int el = (256 - dt - d > 0) ? 256 - dt - d : 0;
      check((k == 0) ? "R3 high-side count" : "R5 high-side count", hc[k], eh);
      check((d == 0) ? "R4 low-side count" : "R8 low-side count", lc[k], el);
    end
    check("R10 overlap", both, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int u;
    int cnt;
    for (int i = 0; i < 16; i++)
      tbl[i] = $rtoi(127.0 * $sin((2.0 * i + 1.0) * 3.14159265358979 / 64.0) + 0.5);

    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {29'd0, hs}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 hs after reset", {29'd0, hs}, 0);
    check("R1 ls after reset", {29'd0, ls}, 0);

    // R2: enabled but wrong mode, ticks must be ignored
    enable = 1'b1; mode = 2'd1;
    cnt = 0;
    fork
      pulse_ticks(6);
      repeat (300) begin @(negedge clk); cnt += int'(hs != 0 || ls != 0); end
    join
    check("R2 idle outputs", cnt, 0);

    mode = 2'd2;
    u = 0;
    for (int s = 0; s < 64; s++) begin   // R7 increment
      check_step(u, 21, 0);
      pulse_ticks(3);
      u = (u + 1) & 63;
    end

    // R6: period 5 needs five strobes for one step
    step_period = 16'd5;
    pulse_ticks(4);
    check_step(u, 21, 0);
    pulse_ticks(1);
    u = (u + 1) & 63;
    check_step(u, 21, 0);

    // R2: enable low freezes the index
    enable = 1'b0;
    pulse_ticks(7);
    @(negedge clk);
    check("R2 disabled outputs", {29'd0, hs | ls}, 0);
    enable = 1'b1;
    check_step(u, 21, 0);

    // R9: brake overrides active and inactive states
    brake_n = 1'b0;
    #1;
    check("R9 hs under brake", {29'd0, hs}, 0);
    check("R9 ls under brake", {29'd0, ls}, 7);
    enable = 1'b0;
    #1;
    check("R9 ls under brake disabled", {29'd0, ls}, 7);
    enable = 1'b1; brake_n = 1'b1;

    // R7 decrement with dead time R8 and another spacing R5
    step_period = 16'd3; dir = 1'b0; dead_ticks = 4'd3; phase_gap = 16'd43;
    for (int s = 0; s < 64; s++) begin
      check_step(u, 43, 3);
      pulse_ticks(3);
      u = (u - 1) & 63;
    end

    // R5: spacing taken modulo 64
    phase_gap = 16'd64 + 16'd10; dead_ticks = 4'd0;
    check_step(u, 10, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule